// File: doc/BRIEF.md
# Memory Bandwidth Test Engine

This engine sits on the user clock of an external DRAM controller and drives the controller's user-side command and data port. Its job is to measure sustained throughput and check data integrity. After a start pulse it writes a deterministic pattern to every word of an address window. It then reads the whole window back and compares each returned word against the same pattern, regenerated in return order. One data word travels with each command and covers one full burst.

Each pass has its own cycle timer and its own accepted-command counter, and a miscompare counter tracks bad read words. All five results are 32 bits wide and stay frozen while the done flag is high, so a host can report them after the run.

A mode input selects how commands are issued:

- **Paced mode** leaves at least four user-clock cycles between command acceptances.
- **Back-to-back mode** presents a new command on every cycle in which the controller is ready.

Top module: `bw_test_engine`

## Requirements
- R1: A run writes every address from `base_addr` to `end_addr` inclusive, in ascending steps of `ADDR_STEP`. All writes (`mc_cmd` = 3'b000) are accepted before any read (`mc_cmd` = 3'b001) is presented. The reads then cover the same addresses in the same order.
- R2: Each write command has exactly one data word, presented with `mc_wr_vld` and `mc_wr_last` high. The word for address a is `{DATA_W/32{32'(a)}} ^ PAT_KEY`.
- R3: Once presented, a command keeps `mc_cmd_vld`, `mc_cmd` and `mc_addr` unchanged until the cycle in which `mc_cmd_rdy` is high. A write word likewise keeps `mc_wr_vld` and `mc_wr_data` unchanged until `mc_wr_rdy` is high.
- R4: In paced mode (`paced_mode` = 1 at start), any two accepted commands are at least four cycles apart.
- R5: In back-to-back mode, with both ready inputs held high, one command is accepted on every cycle of each pass and across the switch from writing to reading.
- R6: `wr_cycles` counts every cycle from the first cycle a write command is presented through the cycle the last write command and its data are accepted, inclusive.
- R7: `rd_cycles` counts every cycle from the first cycle a read command is presented through the cycle the last read word returns, inclusive.
- R8: `wr_cmds` and `rd_cmds` count the commands accepted in each pass. For a window of N words, both equal N.
- R9: `err_cnt` increments once for each returned read word that differs from the R2 pattern for its address. It is zero on a clean run.
- R10: `done` rises only after the number of returned read words equals `rd_cmds`. It stays high, with all results held, until the next start.
- R11: After reset, `done`, `mc_cmd_vld`, `mc_wr_vld` and all five result counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller user clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a run when idle or done |
| paced_mode | input | 1 | 1: paced issue, 0: back-to-back issue |
| base_addr | input | ADDR_W | First word address of the window |
| end_addr | input | ADDR_W | Last word address of the window |
| done | output | 1 | Run complete, results valid |
| mc_cmd | output | 3 | Command code, 000 write, 001 read |
| mc_addr | output | ADDR_W | Command address |
| mc_cmd_vld | output | 1 | Command presented |
| mc_cmd_rdy | input | 1 | Controller accepts command |
| mc_wr_data | output | DATA_W | Write data word |
| mc_wr_vld | output | 1 | Write data presented |
| mc_wr_last | output | 1 | Last word of the burst (always with valid) |
| mc_wr_rdy | input | 1 | Controller accepts write data |
| mc_rd_data | input | DATA_W | Returned read word |
| mc_rd_vld | input | 1 | Read word valid |
| wr_cycles | output | CNT_W | Write pass duration in cycles |
| rd_cycles | output | CNT_W | Read pass duration in cycles |
| wr_cmds | output | CNT_W | Accepted write commands |
| rd_cmds | output | CNT_W | Accepted read commands |
| err_cnt | output | CNT_W | Miscompared read words |

## Verification
Results are due on the edge at which `done` rises, so the scoreboard waits for that edge and compares one half-cycle later. At that point the counters are final.

The behavioural controller returns each read word three cycles after the command is accepted. The expected durations follow from this, with ready held high:

- Back-to-back: `wr_cycles` is N and `rd_cycles` is N+3.
- Paced: `wr_cycles` is 4(N-1)+1 and `rd_cycles` is 4(N-1)+4.

Command gaps and hold behaviour are sampled on falling edges, which is away from the edge at which the controller model captures a command. Runs with random stalls on the ready inputs check only the counts, the pattern, the gaps and the stability rules, never the durations.

// File: rtl/bw_test_engine.sv
module bw_test_engine #(
  parameter int ADDR_W    = 28,
  parameter int DATA_W    = 128,
  parameter int ADDR_STEP = 8,
  parameter int CNT_W     = 32,
  parameter logic [DATA_W-1:0] PAT_KEY = {(DATA_W/32){32'hA5C3_0F96}}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              paced_mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              done,
  output logic [2:0]        mc_cmd,
  output logic [ADDR_W-1:0] mc_addr,
  output logic              mc_cmd_vld,
  input  logic              mc_cmd_rdy,
  output logic [DATA_W-1:0] mc_wr_data,
  output logic              mc_wr_vld,
  output logic              mc_wr_last,
  input  logic              mc_wr_rdy,
  input  logic [DATA_W-1:0] mc_rd_data,
  input  logic              mc_rd_vld,
  output logic [CNT_W-1:0]  wr_cycles,
  output logic [CNT_W-1:0]  rd_cycles,
  output logic [CNT_W-1:0]  wr_cmds,
  output logic [CNT_W-1:0]  rd_cmds,
  output logic [CNT_W-1:0]  err_cnt
);
  localparam int REPS = DATA_W / 32;
  localparam logic [2:0] CMD_WR = 3'b000;
  localparam logic [2:0] CMD_RD = 3'b001;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_DRAIN, S_DONE} st_t;

  st_t               state;
  logic              cvld, dvld, cmd_rd, paced_q;
  logic              wr_go, rd_go, nxt_rd, issue_fin;
  logic [1:0]        pace_cnt;
  logic [ADDR_W-1:0] addr_q, nxt_addr, chk_addr, base_q, end_q;
  logic [CNT_W-1:0]  rx_cnt;

  function automatic logic [DATA_W-1:0] pat(input logic [ADDR_W-1:0] a);
    logic [31:0] w;
    w = 32'(a);
    return {REPS{w}} ^ PAT_KEY;
  endfunction

  wire cmd_fire  = cvld & mc_cmd_rdy;
  wire dat_fire  = dvld & mc_wr_rdy;
  wire slot_done = (cvld | dvld) & (!cvld | mc_cmd_rdy) & (!dvld | mc_wr_rdy);
  wire slot_free = !(cvld | dvld) | slot_done;
  wire pace_ok   = !paced_q | (pace_cnt >= 2'd2 && !cmd_fire);
  wire running   = (state == S_WR) || (state == S_RD);
  wire load      = running && !issue_fin && slot_free && pace_ok;
  wire rd_phase  = (state == S_RD) || (state == S_DRAIN);
  wire last_slot = slot_done && (addr_q == end_q);
  wire [CNT_W-1:0] rx_next = rx_cnt + CNT_W'(mc_rd_vld && rd_phase);

  assign done       = (state == S_DONE);
  assign mc_cmd     = cmd_rd ? CMD_RD : CMD_WR;
  assign mc_addr    = addr_q;
  assign mc_cmd_vld = cvld;
  assign mc_wr_data = pat(addr_q);
  assign mc_wr_vld  = dvld;
  assign mc_wr_last = dvld;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cvld <= 1'b0; dvld <= 1'b0; cmd_rd <= 1'b0; paced_q <= 1'b0;
      wr_go <= 1'b0; rd_go <= 1'b0; nxt_rd <= 1'b0; issue_fin <= 1'b0;
      pace_cnt <= 2'd3;
      addr_q <= '0; nxt_addr <= '0; chk_addr <= '0; base_q <= '0; end_q <= '0;
      rx_cnt <= '0;
      wr_cycles <= '0; rd_cycles <= '0; wr_cmds <= '0; rd_cmds <= '0; err_cnt <= '0;
    end else begin
      if (cmd_fire) pace_cnt <= 2'd0;
      else if (pace_cnt != 2'd3) pace_cnt <= pace_cnt + 2'd1;
      if (cmd_fire) cvld <= 1'b0;
      if (dat_fire) dvld <= 1'b0;

      if (load) begin
        cvld   <= 1'b1;
        dvld   <= !nxt_rd;
        addr_q <= nxt_addr;
        cmd_rd <= nxt_rd;
        if (nxt_rd) rd_go <= 1'b1;
        else        wr_go <= 1'b1;
        if (nxt_addr == end_q) begin
          if (nxt_rd) issue_fin <= 1'b1;
          else begin
            nxt_rd   <= 1'b1;
            nxt_addr <= base_q;
          end
        end else begin
          nxt_addr <= nxt_addr + STEP;
        end
      end

      if (cmd_fire && !cmd_rd) wr_cmds <= wr_cmds + 1'b1;
      if (cmd_fire &&  cmd_rd) rd_cmds <= rd_cmds + 1'b1;
      if (state == S_WR && wr_go) wr_cycles <= wr_cycles + 1'b1;
      if (rd_phase && rd_go) rd_cycles <= rd_cycles + 1'b1;

      if (mc_rd_vld && rd_phase) begin
        rx_cnt   <= rx_next;
        chk_addr <= chk_addr + STEP;
        if (mc_rd_data != pat(chk_addr)) err_cnt <= err_cnt + 1'b1;
      end

      case (state)
        S_WR:    if (last_slot && !cmd_rd) state <= S_RD;
        S_RD:    if (last_slot &&  cmd_rd) state <= S_DRAIN;
        S_DRAIN: if (rx_next == rd_cmds) state <= S_DONE;
        default: begin
          if (start) begin
            state <= S_WR;
            paced_q <= paced_mode;
            base_q <= base_addr; end_q <= end_addr;
            nxt_addr <= base_addr; chk_addr <= base_addr;
            nxt_rd <= 1'b0; issue_fin <= 1'b0;
            wr_go <= 1'b0; rd_go <= 1'b0;
            pace_cnt <= 2'd3;
            rx_cnt <= '0;
            wr_cycles <= '0; rd_cycles <= '0; wr_cmds <= '0; rd_cmds <= '0; err_cnt <= '0;
          end
        end
      endcase
    end
  end

  p_hold_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    (mc_cmd_vld && !mc_cmd_rdy) |=> (mc_cmd_vld && $stable(mc_addr) && $stable(mc_cmd)));

  p_hold_data_r3: assert property (@(posedge clk) disable iff (rst)
    (mc_wr_vld && !mc_wr_rdy) |=> (mc_wr_vld && $stable(mc_wr_data)));

  p_pace_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (paced_q && mc_cmd_vld && mc_cmd_rdy) |=>
      !(mc_cmd_vld && mc_cmd_rdy) ##1 !(mc_cmd_vld && mc_cmd_rdy) ##1 !(mc_cmd_vld && mc_cmd_rdy));

  p_b2b_next_r5: assert property (@(posedge clk) disable iff (rst)
    (!paced_q && mc_cmd_vld && mc_cmd_rdy && mc_cmd == CMD_RD && mc_addr != end_q) |=> mc_cmd_vld);

  p_read_after_writes_r1: assert property (@(posedge clk) disable iff (rst)
    (mc_cmd_vld && mc_cmd == CMD_RD) |-> (state != S_WR && wr_cmds != '0));

  p_done_complete_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> (rx_cnt == rd_cmds && rd_cmds == wr_cmds));
endmodule

// File: tb/bw_test_engine_tb.sv
module bw_test_engine_tb;
  localparam int AW = 28, DW = 128, STEP = 8, LAT = 3, CW = 32;
  localparam logic [DW-1:0] KEY = {4{32'hA5C3_0F96}};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, paced_mode, done;
  logic [AW-1:0] base_addr, end_addr, mc_addr;
  logic [2:0] mc_cmd;
  logic mc_cmd_vld, mc_cmd_rdy, mc_wr_vld, mc_wr_last, mc_wr_rdy, mc_rd_vld;
  logic [DW-1:0] mc_wr_data, mc_rd_data;
  logic [CW-1:0] wr_cycles, rd_cycles, wr_cmds, rd_cmds, err_cnt;

  bw_test_engine #(.ADDR_W(AW), .DATA_W(DW), .ADDR_STEP(STEP), .CNT_W(CW), .PAT_KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .start(start), .paced_mode(paced_mode),
    .base_addr(base_addr), .end_addr(end_addr), .done(done),
    .mc_cmd(mc_cmd), .mc_addr(mc_addr), .mc_cmd_vld(mc_cmd_vld), .mc_cmd_rdy(mc_cmd_rdy),
    .mc_wr_data(mc_wr_data), .mc_wr_vld(mc_wr_vld), .mc_wr_last(mc_wr_last), .mc_wr_rdy(mc_wr_rdy),
    .mc_rd_data(mc_rd_data), .mc_rd_vld(mc_rd_vld),
    .wr_cycles(wr_cycles), .rd_cycles(rd_cycles), .wr_cmds(wr_cmds), .rd_cmds(rd_cmds), .err_cnt(err_cnt));

  int n_cmp = 0, n_bad = 0;

  function automatic logic [DW-1:0] expect_word(input logic [AW-1:0] a);
    return {4{32'(a)}} ^ KEY;
  endfunction

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural controller
  bit stall_en = 0, bad_en = 0;
  logic [AW-1:0] bad_addr = '0;
  logic cmd_rdy_r = 1'b1, wr_rdy_r = 1'b1;
  logic [DW:0] pipe [0:LAT-1];
  logic [DW-1:0] mem [0:255];
  logic [AW-1:0] wq[$];
  logic [DW-1:0] dq[$];
  logic [DW-1:0] rdata;
  logic [AW-1:0] exp_waddr = '0;
  bit seen_rd = 0;
  int order_viol = 0;

  assign mc_cmd_rdy = cmd_rdy_r;
  assign mc_wr_rdy  = wr_rdy_r;
  assign mc_rd_vld  = pipe[LAT-1][DW];
  assign mc_rd_data = pipe[LAT-1][DW-1:0];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) pipe[i] <= '0;
    end else begin
      if (stall_en) begin
        cmd_rdy_r <= ($urandom_range(0, 3) != 0);
        wr_rdy_r  <= ($urandom_range(0, 3) != 0);
      end else begin
        cmd_rdy_r <= 1'b1;
        wr_rdy_r  <= 1'b1;
      end
      for (int i = LAT - 1; i > 0; i--) pipe[i] <= pipe[i-1];
      pipe[0] <= '0;
      if (start) begin
        seen_rd = 0; exp_waddr = base_addr; order_viol = 0;
      end
      if (mc_cmd_vld && mc_cmd_rdy) begin
        if (mc_cmd == 3'b000) begin
          if (seen_rd || mc_addr != exp_waddr) order_viol++;
          exp_waddr = exp_waddr + AW'(STEP);
          wq.push_back(mc_addr);
        end else begin
          if (!seen_rd) exp_waddr = base_addr;
          seen_rd = 1;
          if (mc_addr != exp_waddr || mc_cmd != 3'b001) order_viol++;
          exp_waddr = exp_waddr + AW'(STEP);
          rdata = mem[(mc_addr / STEP) % 256];
          if (bad_en && mc_addr == bad_addr) rdata[5] = ~rdata[5];
          pipe[0] <= {1'b1, rdata};
        end
      end
      if (mc_wr_vld && mc_wr_rdy) begin
        if (!mc_wr_last) order_viol++;
        dq.push_back(mc_wr_data);
      end
      if (wq.size() > 0 && dq.size() > 0) mem[(wq.pop_front() / STEP) % 256] = dq.pop_front();
    end
  end

  // interface monitor on falling edges
  int cyc = 0, last_fire = 0, min_gap = 1000, hold_viol = 0;
  bit have_last = 0, c_pend = 0, d_pend = 0;
  logic [AW-1:0] p_addr;
  logic [2:0] p_cmd;
  logic [DW-1:0] p_data;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (start) begin have_last = 0; min_gap = 1000; end
      if (c_pend && (!mc_cmd_vld || mc_addr != p_addr || mc_cmd != p_cmd)) hold_viol++;
      if (d_pend && (!mc_wr_vld || mc_wr_data != p_data)) hold_viol++;
      c_pend = mc_cmd_vld && !mc_cmd_rdy; p_addr = mc_addr; p_cmd = mc_cmd;
      d_pend = mc_wr_vld && !mc_wr_rdy;   p_data = mc_wr_data;
      if (mc_cmd_vld && mc_cmd_rdy) begin
        if (have_last && cyc - last_fire < min_gap) min_gap = cyc - last_fire;
        last_fire = cyc; have_last = 1;
      end
    end
  end

  // scoreboard
  typedef struct {string tag; int sel; longint unsigned exp;} item_t;
  item_t sbq[$];
  logic [AW-1:0] cur_base, cur_end;

  function automatic longint unsigned actual(input int sel);
    int mm;
    case (sel)
      0: return wr_cmds;
      1: return rd_cmds;
      2: return err_cnt;
      3: return wr_cycles;
      4: return rd_cycles;
      5: return min_gap;
      6: begin
           mm = 0;
           for (logic [AW-1:0] a = cur_base; a <= cur_end; a += AW'(STEP))
             if (mem[(a / STEP) % 256] !== expect_word(a)) mm++;
           return mm;
         end
      7: return order_viol;
      8: return (min_gap >= 4) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    item_t it;
    forever begin
      @(posedge done);
      @(negedge clk);
      while (sbq.size() != 0) begin
        it = sbq.pop_front();
        check(it.tag, actual(it.sel), it.exp);
      end
    end
  end

  task automatic push(input string tag, input int sel, input longint unsigned exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic run(input bit pm, input bit stl, input logic [AW-1:0] b, input logic [AW-1:0] e,
                     input bit bad, input logic [AW-1:0] ba);
    int n;
    n = int'((e - b) / STEP) + 1;
    push("R8 write count", 0, n);
    push("R8 read count", 1, n);
    push("R9 miscompares", 2, bad ? 1 : 0);
    push("R2 stored pattern", 6, 0);
    push("R1 order and addresses", 7, 0);
    if (pm) push("R4 min gap >= 4", 8, 1);
    if (!stl && pm) begin
      push("R6 write timer paced", 3, 4 * (n - 1) + 1);
      push("R7 read timer paced", 4, 4 * (n - 1) + 1 + LAT);
      push("R4 min gap exact", 5, 4);
    end
    if (!stl && !pm) begin
      push("R6 write timer b2b", 3, n);
      push("R7 read timer b2b", 4, n + LAT);
      push("R5 b2b gap", 5, 1);
    end
    @(negedge clk);
    stall_en = stl; bad_en = bad; bad_addr = ba;
    cur_base = b; cur_end = e;
    paced_mode = pm; base_addr = b; end_addr = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20000 && sbq.size() != 0; k++) @(negedge clk);
    if (sbq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 run timeout: actual done=%0b expected 1", done);
      sbq.delete();
    end
    @(negedge clk);
    check("R10 done held", done, 1);
    check("R10 results held", wr_cmds, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; paced_mode = 1'b0; base_addr = '0; end_addr = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 done", done, 0);
    check("R11 cmd valid", mc_cmd_vld, 0);
    check("R11 write valid", mc_wr_vld, 0);
    check("R11 counters", wr_cycles | rd_cycles | wr_cmds | rd_cmds | err_cnt, 0);

    run(0, 0, 28'h000, 28'h078, 0, '0);   // 16 words back-to-back
    run(1, 0, 28'h100, 28'h138, 0, '0);   // 8 words paced
    run(0, 1, 28'h200, 28'h3F8, 0, '0);   // 64 words with stalls
    run(1, 1, 28'h600, 28'h658, 0, '0);   // 12 words paced with stalls
    run(0, 0, 28'h7F8, 28'h7F8, 1, 28'h7F8); // single word, corrupted
    run(1, 0, 28'h040, 28'h088, 1, 28'h060); // paced, one corrupted word
    run(0, 0, 28'h040, 28'h088, 1, 28'h080); // b2b, one corrupted word

    check("R3 hold violations", hold_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule